// File: doc/BRIEF.md
# SPI Master Frame Sequencer

This block is a synchronous serial master. It takes words from an external transmit queue and shifts them out most significant bit first. It drives four lines. The serial clock rests high. The frame select is active low. The transmit line has its own output-enable. The receive line is sampled by the block. Every output is a register in the system clock domain, and the serial clock half period is a programmable count of system clock cycles.

A phase input picks one of two timings.

- With phase clear, the receive line is sampled on falling serial clock edges and the transmit data moves on rising edges. Frame select goes high between words, even in a continuous burst.
- With phase set, data is launched on falling edges and sampled on rising edges. Frame select stays low through a back-to-back burst.

In both modes, frame select returns high one full serial clock period after the last sample. Each received word is presented right-aligned, with a one-cycle valid flag.

Top module: `spi_frame_master`

## Requirements
- R1: After reset and whenever no frame is active, `sclk`=1, `fssN`=1, `txdOe`=0 and `sclkOe`=1. While `fssN` is high the serial clock never changes and the transmit driver stays off.
- R2: A frame starts only at an edge where `enable` and `txValid` are both 1. At that edge `fssN` falls and `txdOe` rises together. `txAck` pulses high for exactly one cycle in the following cycle, once per word taken.
- R3: With `cpha`=0, the MSB is driven on `txd` one half period (H system cycles) after `fssN` falls. The first falling `sclk` edge comes 2H cycles after `fssN` falls. `rxd` is sampled at falling edges and `txd` changes at rising edges.
- R4: With `cpha`=1, the first falling `sclk` edge comes H cycles after `fssN` falls. `txd` changes at falling edges and `rxd` is sampled at rising edges.
- R5: The word length N is taken from `wordLen` when a word is loaded and clamped to the range 4..16. Values below 4 give 4, and values above 16 give 16. Each word produces exactly N falling `sclk` edges. Bits go out and come in MSB first. Only the low N bits of `txData` are sent.
- R6: After the last sample of a word, `rxData` holds the N received bits in bits N-1..0, with zeros above. `rxValid` is high for exactly one cycle, while `fssN` is still low.
- R7: After the final word of a frame, `fssN` rises exactly 2H system cycles after the edge that samples the last bit.
- R8: With `cpha`=0 and more words queued, `fssN` goes high for H cycles between words, and each word opens its own frame.
- R9: With `cpha`=1 and the next word available at the end of a word, `fssN` stays low. The next word's MSB is launched on the falling edge H cycles after the previous last sample.
- R10: If `enable` goes low during a word, that word completes and its data is delivered. No further word is taken, and all lines return to the R1 idle state.
- R11: The half period H equals `halfDiv` system cycles. A value of 0 is treated as 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Allows new words to be taken |
| cpha | input | 1 | Phase select: 0 = sample on fall with a frame-select pulse between words, 1 = sample on rise with a continuous frame |
| wordLen | input | 5 | Word length in bits, clamped to 4..16 |
| halfDiv | input | DIV_W | Serial clock half period in system cycles (0 treated as 1) |
| txData | input | 16 | Head word of the transmit queue, right-aligned |
| txValid | input | 1 | Transmit queue holds a word |
| txAck | output | 1 | One-cycle pop strobe for the transmit queue |
| rxd | input | 1 | Serial receive line |
| rxData | output | 16 | Last received word, right-aligned, upper bits zero |
| rxValid | output | 1 | One-cycle flag: a new word is in `rxData` |
| sclk | output | 1 | Serial clock, idles high |
| sclkOe | output | 1 | Serial clock driver enable, always on for a master |
| fssN | output | 1 | Frame select, active low |
| txd | output | 1 | Serial transmit data |
| txdOe | output | 1 | Transmit line driver enable, 0 = tristated |

## Verification
In a phase-set burst, two events meet on one system edge. The load of the next word and the launch of its MSB both happen there, on the edge where the clock falls after the previous word's final half period. The bench provokes this with back-to-back words fed through a loopback. It judges the case by the second received word and by a single rise of frame select across the burst. The other collision is `enable` dropping in the middle of a word, so that the end-of-word decision sees the block disabled while a queued word is still valid. The bench checks that exactly one word is delivered, that the queue keeps its second word, and that every line is back at idle.

// File: rtl/spim_pkg.sv
package spim_pkg;
  localparam int DATA_W  = 16;
  localparam int MIN_LEN = 4;
  localparam int LEN_W   = $clog2(DATA_W + 1);
  localparam int IDX_W   = LEN_W + 1;

  typedef enum logic [2:0] {
    ST_IDLE, ST_LEAD, ST_SETUP, ST_SHIFT, ST_TAIL, ST_GAP
  } spimState_t;

  // strobes from sequencer to datapath
  typedef struct packed {
    logic             load;
    logic             launch;
    logic             capture;
    logic             lastCap;
    logic [LEN_W-1:0] len;
  } spimStrobe_t;
endpackage

// File: rtl/spim_ctrl.sv
module spim_ctrl import spim_pkg::*; #(
  parameter int DIV_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             enable,
  input  logic             cpha,
  input  logic [LEN_W-1:0] wordLen,
  input  logic [DIV_W-1:0] halfDiv,
  input  logic             txValid,
  output spimStrobe_t      stb,
  output logic             sclk,
  output logic             fssN,
  output logic             txdOe,
  output logic             txAck
);
  spimState_t       state;
  logic [DIV_W-1:0] halfCnt, divEff;
  logic [IDX_W-1:0] halfIdx, nextIdx;
  logic [LEN_W-1:0] lenQ, lenEff, bitNext;
  logic             phQ, tick, startOk, lastHalf;

  assign divEff   = (halfDiv == '0) ? DIV_W'(1) : halfDiv;
  assign tick     = (state != ST_IDLE) && (halfCnt == divEff - DIV_W'(1));
  assign startOk  = enable && txValid;
  assign nextIdx  = halfIdx + IDX_W'(1);
  assign bitNext  = nextIdx[IDX_W-1:1];
  assign lastHalf = (halfIdx == ({lenQ, 1'b0} - IDX_W'(1)));

  always_comb begin
    if (wordLen < LEN_W'(MIN_LEN))     lenEff = LEN_W'(MIN_LEN);
    else if (wordLen > LEN_W'(DATA_W)) lenEff = LEN_W'(DATA_W);
    else                               lenEff = wordLen;
  end

  always_comb begin
    stb = '0;
    stb.len = lenEff;
    unique case (state)
      ST_IDLE:  stb.load = startOk;
      ST_LEAD:  stb.launch = tick;
      ST_SETUP: stb.capture = tick;
      ST_SHIFT: if (tick) begin
        if (lastHalf) begin
          stb.load   = phQ && startOk;
          stb.launch = phQ && startOk;
        end else if (nextIdx[0] != phQ) begin
          // odd half with phase clear: rising edge; even half with phase set: falling edge
          stb.launch = !phQ || (bitNext < lenQ);
          if (!phQ) stb.launch = (bitNext < lenQ - LEN_W'(1));
        end else begin
          stb.capture = 1'b1;
          stb.lastCap = (bitNext == lenQ - LEN_W'(1));
        end
      end
      ST_GAP:   stb.load = tick && startOk;
      default:  ;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE; halfCnt <= '0; halfIdx <= '0; lenQ <= LEN_W'(MIN_LEN);
      phQ <= 1'b0; sclk <= 1'b1; fssN <= 1'b1; txdOe <= 1'b0; txAck <= 1'b0;
    end else begin
      txAck   <= 1'b0;
      halfCnt <= (tick || state == ST_IDLE) ? '0 : halfCnt + DIV_W'(1);
      if (stb.load) begin
        lenQ  <= lenEff;
        txAck <= 1'b1;
      end
      unique case (state)
        ST_IDLE: if (startOk) begin
          state <= ST_LEAD; fssN <= 1'b0; txdOe <= 1'b1; phQ <= cpha;
        end
        ST_LEAD: if (tick) begin
          state <= phQ ? ST_SHIFT : ST_SETUP;
          halfIdx <= '0;
          if (phQ) sclk <= 1'b0;
        end
        ST_SETUP: if (tick) begin
          state <= ST_SHIFT; halfIdx <= '0; sclk <= 1'b0;
        end
        ST_SHIFT: if (tick) begin
          if (lastHalf) begin
            if (phQ && startOk) begin
              halfIdx <= '0; sclk <= 1'b0;
            end else if (phQ) begin
              state <= ST_TAIL;
            end else begin
              state <= ST_GAP; fssN <= 1'b1; txdOe <= 1'b0;
            end
          end else begin
            halfIdx <= nextIdx;
            sclk    <= nextIdx[0];
          end
        end
        ST_TAIL: if (tick) begin
          state <= ST_GAP; fssN <= 1'b1; txdOe <= 1'b0;
        end
        ST_GAP: if (tick) begin
          if (startOk) begin
            state <= ST_LEAD; fssN <= 1'b0; txdOe <= 1'b1; phQ <= cpha;
          end else begin
            state <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/spim_dp.sv
module spim_dp import spim_pkg::*; (
  input  logic              clk,
  input  logic              rstN,
  input  spimStrobe_t       stb,
  input  logic [DATA_W-1:0] txData,
  input  logic              rxd,
  output logic              txd,
  output logic [DATA_W-1:0] rxData,
  output logic              rxValid
);
  logic [DATA_W-1:0] txShift, rxShift, aligned, rxNext;
  logic [LEN_W-1:0]  shAmt;

  assign shAmt   = LEN_W'(DATA_W) - stb.len;
  assign aligned = txData << shAmt;
  assign rxNext  = {rxShift[DATA_W-2:0], rxd};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txShift <= '0; rxShift <= '0; rxData <= '0; rxValid <= 1'b0; txd <= 1'b0;
    end else begin
      rxValid <= 1'b0;
      if (stb.load) begin
        rxShift <= '0;
        if (stb.launch) begin
          txd     <= aligned[DATA_W-1];
          txShift <= aligned << 1;
        end else begin
          txd     <= 1'b0;
          txShift <= aligned;
        end
      end else if (stb.launch) begin
        txd     <= txShift[DATA_W-1];
        txShift <= txShift << 1;
      end
      if (stb.capture) begin
        rxShift <= rxNext;
        if (stb.lastCap) begin
          rxData  <= rxNext;
          rxValid <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/spi_frame_master.sv
module spi_frame_master import spim_pkg::*; #(
  parameter int DIV_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              enable,
  input  logic              cpha,
  input  logic [LEN_W-1:0]  wordLen,
  input  logic [DIV_W-1:0]  halfDiv,
  input  logic [DATA_W-1:0] txData,
  input  logic              txValid,
  output logic              txAck,
  input  logic              rxd,
  output logic [DATA_W-1:0] rxData,
  output logic              rxValid,
  output logic              sclk,
  output logic              sclkOe,
  output logic              fssN,
  output logic              txd,
  output logic              txdOe
);
  spimStrobe_t stb;

  assign sclkOe = 1'b1;

  spim_ctrl #(.DIV_W(DIV_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .enable(enable), .cpha(cpha), .wordLen(wordLen),
    .halfDiv(halfDiv), .txValid(txValid), .stb(stb), .sclk(sclk), .fssN(fssN),
    .txdOe(txdOe), .txAck(txAck)
  );

  spim_dp u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .txData(txData), .rxd(rxd),
    .txd(txd), .rxData(rxData), .rxValid(rxValid)
  );
endmodule

// File: rtl/spim_chk.sv
module spim_chk (
  input logic clk,
  input logic rstN,
  input logic enable,
  input logic txValid,
  input logic txAck,
  input logic fssN,
  input logic sclk,
  input logic txdOe,
  input logic rxValid
);
  // R1: lines parked while frame select is high
  p_idle_lines_r1: assert property (@(posedge clk) disable iff (!rstN)
    fssN |-> (sclk && !txdOe));
  // R1: no clock activity outside a frame
  p_sclk_quiet_r1: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(sclk) |-> !fssN);
  // R2: frame opens only when enabled with data present
  p_start_gate_r2: assert property (@(posedge clk) disable iff (!rstN)
    $fell(fssN) |-> ($past(enable) && $past(txValid) && txdOe));
  // R2: pop strobe is a single-cycle pulse
  p_ack_pulse_r2: assert property (@(posedge clk) disable iff (!rstN)
    txAck |=> !txAck);
  // R6: receive flag is one cycle wide and inside the frame
  p_rx_pulse_r6: assert property (@(posedge clk) disable iff (!rstN)
    rxValid |=> !rxValid);
  p_rx_inframe_r6: assert property (@(posedge clk) disable iff (!rstN)
    rxValid |-> !fssN);
endmodule

bind spi_frame_master spim_chk u_chk (
  .clk(clk), .rstN(rstN), .enable(enable), .txValid(txValid), .txAck(txAck),
  .fssN(fssN), .sclk(sclk), .txdOe(txdOe), .rxValid(rxValid)
);

// File: tb/sim_spi_frame_master.sv
module sim_spi_frame_master;
  localparam int CLK_PERIOD = 10;
  localparam int DIV_W = 4;

  typedef struct packed {
    logic        cpha;
    logic [4:0]  len;
    logic [3:0]  div;
    logic [15:0] data;
    logic        inv;
    logic [1:0]  nWords;
  } vec_t;

  localparam int NVEC = 8;
  localparam vec_t VECS [NVEC] = '{
    '{1'b0, 5'd8,  4'd2, 16'hA5C3, 1'b0, 2'd1},
    '{1'b1, 5'd8,  4'd2, 16'h3C96, 1'b0, 2'd1},
    '{1'b0, 5'd16, 4'd1, 16'h8001, 1'b1, 2'd1},
    '{1'b1, 5'd4,  4'd3, 16'hFFF9, 1'b0, 2'd1},
    '{1'b0, 5'd12, 4'd0, 16'h0ABC, 1'b0, 2'd2},
    '{1'b1, 5'd16, 4'd2, 16'h1234, 1'b1, 2'd2},
    '{1'b1, 5'd3,  4'd1, 16'h0005, 1'b0, 2'd2},
    '{1'b0, 5'd20, 4'd1, 16'hF00F, 1'b0, 2'd1}
  };

  logic clk = 1'b0, rstN = 1'b0, enable = 1'b0, cpha = 1'b0, invLoop = 1'b0;
  logic [4:0] wordLen = 5'd8;
  logic [DIV_W-1:0] halfDiv = 4'd2;
  logic [15:0] txData, rxData;
  logic txValid, txAck, rxd, rxValid, sclk, sclkOe, fssN, txd, txdOe;

  logic [15:0] fifoMem [4];
  int fifoCnt = 0, fifoIdx = 0;
  assign txValid = fifoIdx < fifoCnt;
  assign txData  = fifoMem[fifoIdx % 4];
  assign rxd     = txdOe ? (txd ^ invLoop) : 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) if (txAck) fifoIdx <= fifoIdx + 1;

  spi_frame_master #(.DIV_W(DIV_W)) u0 (
    .clk(clk), .rstN(rstN), .enable(enable), .cpha(cpha), .wordLen(wordLen),
    .halfDiv(halfDiv), .txData(txData), .txValid(txValid), .txAck(txAck),
    .rxd(rxd), .rxData(rxData), .rxValid(rxValid), .sclk(sclk), .sclkOe(sclkOe),
    .fssN(fssN), .txd(txd), .txdOe(txdOe)
  );

  // monitor, sampled at falling system edges
  int cyc = 0, tFall = 0, tRx = 0, lead = 0, rel = 0;
  int sclkFalls = 0, fssRises = 0, rxCount = 0;
  logic [15:0] rxWords [64];
  logic prevSclk = 1'b1, prevFss = 1'b1, leadPending = 1'b0;
  always @(negedge clk) begin
    cyc <= cyc + 1;
    if (prevFss && !fssN) begin tFall <= cyc; leadPending <= 1'b1; end
    if (!prevFss && fssN) begin fssRises <= fssRises + 1; rel <= cyc - tRx; end
    if (prevSclk && !sclk) begin
      sclkFalls <= sclkFalls + 1;
      if (leadPending) begin lead <= cyc - tFall; leadPending <= 1'b0; end
    end
    if (rxValid) begin rxWords[rxCount % 64] <= rxData; rxCount <= rxCount + 1; tRx <= cyc; end
    prevSclk <= sclk; prevFss <= fssN;
  end

  int nChecks = 0, nFails = 0;
  task automatic chk(input string tag, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog R1 actual=timeout expected=completion");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  task automatic push(input logic [15:0] w);
    fifoMem[fifoCnt % 4] = w;
    fifoCnt++;
  endtask

  task automatic waitDone(input int target);
    for (int i = 0; i < 20000; i++) begin
      @(negedge clk);
      if (rxCount >= target && fssN) break;
    end
    repeat (12) @(negedge clk);
  endtask

  function automatic int effLen(input int l);
    return (l < 4) ? 4 : (l > 16) ? 16 : l;
  endfunction

  initial begin
    repeat (4) @(negedge clk);
    // R1: state after reset
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1 reset sclk", sclk, 1);
    chk("R1 reset fssN", fssN, 1);
    chk("R1 reset txdOe", txdOe, 0);
    chk("R1 reset sclkOe", sclkOe, 1);
    chk("R1 reset rxValid", rxValid, 0);

    // table walk
    for (int v = 0; v < NVEC; v++) begin
      automatic vec_t t = VECS[v];
      automatic int n = effLen(int'(t.len));
      automatic int h = (t.div == 0) ? 1 : int'(t.div);
      automatic logic [15:0] mask = 16'((32'd1 << n) - 1);
      automatic logic [15:0] w2 = {t.data[7:0], t.data[15:8]};
      automatic int rx0 = rxCount, f0 = fssRises, s0 = sclkFalls;
      cpha = t.cpha; wordLen = t.len; halfDiv = t.div; invLoop = t.inv;
      push(t.data);
      if (t.nWords == 2) push(w2);
      enable = 1'b1;
      waitDone(rx0 + int'(t.nWords));
      enable = 1'b0;
      chk($sformatf("R5 R6 vec%0d word0", v), rxWords[rx0 % 64], (t.inv ? ~t.data : t.data) & mask);
      if (t.nWords == 2)
        chk($sformatf("R6 R8 R9 vec%0d word1", v), rxWords[(rx0 + 1) % 64], (t.inv ? ~w2 : w2) & mask);
      chk($sformatf("R5 vec%0d sclk falls", v), sclkFalls - s0, n * int'(t.nWords));
      if (t.cpha) chk($sformatf("R4 R11 vec%0d lead", v), lead, h);
      else        chk($sformatf("R3 R11 vec%0d lead", v), lead, 2 * h);
      chk($sformatf("R7 vec%0d release", v), rel, 2 * h);
      chk($sformatf("R8 R9 vec%0d frames", v), fssRises - f0, t.cpha ? 1 : int'(t.nWords));
    end

    // R2: a queued word with enable low is not taken
    begin
      automatic int f0 = fssRises, rx0 = rxCount;
      cpha = 1'b0; wordLen = 5'd6; halfDiv = 4'd1; invLoop = 1'b0;
      push(16'h002D);
      repeat (30) @(negedge clk);
      chk("R2 disabled frame", fssRises - f0, 0);
      chk("R2 disabled fssN", fssN, 1);
      chk("R2 disabled queue kept", txValid, 1);
      enable = 1'b1;
      waitDone(rx0 + 1);
      enable = 1'b0;
      chk("R2 word taken after enable", rxWords[rx0 % 64], 16'h002D);
      chk("R2 queue drained", txValid, 0);
    end

    // R10: enable dropped mid-word, both phases
    for (int p = 0; p < 2; p++) begin
      automatic int rx0 = rxCount, s0 = sclkFalls;
      cpha = p[0]; wordLen = 5'd8; halfDiv = 4'd2; invLoop = 1'b0;
      push(16'h00C7); push(16'h0039);
      enable = 1'b1;
      while (sclkFalls == s0) @(negedge clk);
      enable = 1'b0;
      repeat (100) @(negedge clk);
      chk($sformatf("R10 p%0d one word", p), rxCount - rx0, 1);
      chk($sformatf("R10 p%0d data", p), rxWords[rx0 % 64], 16'h00C7);
      chk($sformatf("R10 p%0d idle lines", p), {fssN, sclk, txdOe}, 3'b110);
      chk($sformatf("R10 p%0d second kept", p), txValid, 1);
      enable = 1'b1;
      waitDone(rx0 + 2);
      enable = 1'b0;
      chk($sformatf("R10 p%0d resumed", p), rxWords[(rx0 + 1) % 64], 16'h0039);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule